// File: doc/BRIEF.md
# Reconfiguration Flag Propagation Controller

This block sits in each router of a four-port mesh and lets the router take part in a distributed rebuild of deadlock-free routing after a link fault. A 1-bit flag travels on a dedicated wire in each direction of every link. The first broadcast of a rebuild comes from the node that detected the fault, called the root. That broadcast moves every node into a recovering state and gives each working port an up or down direction. Each later broadcast spreads out along legal turns only, so that every receiver learns which ports lead back to the node that is broadcasting.

The controller holds the recovering bit, a timer that ends recovery, one direction bit per port, and a record of whether the current broadcast has already been seen. Each cycle it decides which ports drive the flag. It reports the ports on which the first copy of each broadcast arrived, together with a strobe, so that the routing-table logic can fill in the entry for the broadcaster. Slot timing comes from outside as a pulse that opens each broadcast window and a bit that says whether the window belongs to this node.

Top module: `rfc_flag_ctrl`

## Requirements
- R1: While normal, a flag on a live port, or the opening of the node's own window with `root_req_i` high, makes `recovering_o` high from the next cycle. In that same next cycle, `rt_clear_o` pulses for exactly one cycle.
- R2: `recovering_o` stays high for exactly NODE_CNT*NODE_CNT cycles and then drops by itself. A flag that arrives in the last recovering cycle is ignored and does not start a new recovery.
- R3: A root drives `flag_o` equal to `link_ok_i` in the same cycle as its window opens. From the next cycle, each of those ports reads down. In every 4-bit vector, bit i is port i, and in `port_up_o` a 1 means up.
- R4: In the root broadcast, each port on which the first flag arrives reads up from the next cycle. One cycle after that arrival, `flag_o` equals the live ports minus the receiving ports.
- R5: During the root broadcast, a port may send the flag while a flag also arrives on it in the same cycle. That port is marked up if `node_id_i` is greater than the neighbour ID on that port (`nbr_id_i[p*ID_W +: ID_W]`), and down otherwise.
- R6: In a later broadcast, if the first flag arrives on any down port, the next cycle forwards to all live ports that did not receive it. If it arrives on up ports only, the next cycle forwards only to live, non-receiving ports that are marked down.
- R7: Port directions do not change in any broadcast after the root broadcast.
- R8: When the node's own window opens while it is recovering, `flag_o` equals `link_ok_i` in that cycle, and its own flag coming back is ignored.
- R9: A flag on a port whose `link_ok_i` bit is low is ignored, and no flag is ever driven on such a port.
- R10: One cycle after the first reception of a broadcast, `rx_valid_o` is high and `rx_mask_o` holds the live receiving ports. At all other times `rx_valid_o` is low.
- R11: Within one window, flags after the first reception produce no report and no forwarding.
- R12: When the node's window opens while it is normal and `root_req_i` is low, nothing happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| node_id_i | input | ID_W | ID of this node |
| nbr_id_i | input | 4*ID_W | Neighbour ID for each port, port p in slice p |
| link_ok_i | input | 4 | Port link is working |
| slot_start_i | input | 1 | First cycle of a broadcast window |
| own_slot_i | input | 1 | The window that is opening belongs to this node |
| root_req_i | input | 1 | A fault is pending; start a rebuild in the own window |
| flag_i | input | 4 | Flag arriving from each neighbour |
| flag_o | output | 4 | Flag sent to each neighbour |
| recovering_o | output | 1 | Recovering state; head flits are held |
| rt_clear_o | output | 1 | One-cycle pulse to invalidate the routing table |
| port_up_o | output | 4 | Direction of each port, 1 = up |
| rx_mask_o | output | 4 | Ports of first reception of the current broadcast |
| rx_valid_o | output | 1 | `rx_mask_o` is valid |

## Verification
The assertions assume that `slot_start_i` opens each window and that at most one node broadcasts per window. They also assume that every flag of a broadcast arrives inside its own window, so a flag never lands in the cycle that opens the next window. The stimulus keeps to these rules. It opens each window with an idle cycle before any arrival, and it places late and crossing flags strictly inside the window. The only flags it drives near a window edge are the ones aimed at the last recovering cycle, and those are meant to be dropped.

// File: rtl/rfc_pkg.sv
package rfc_pkg;
  localparam int unsigned NPORT = 4;
  typedef logic [NPORT-1:0] port_vec_t;
endpackage

// File: rtl/rfc_exit_timer.sv
module rfc_exit_timer #(
  parameter int unsigned NODE_CNT = 16,
  localparam int unsigned NN = NODE_CNT * NODE_CNT,
  localparam int unsigned CW = (NN > 1) ? $clog2(NN) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic active_o,
  output logic last_o
);
  logic [CW-1:0] cnt_q;
  logic          act_q;

  assign active_o = act_q;
  assign last_o   = act_q && (cnt_q == CW'(NN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_i) begin
      act_q <= 1'b1;
      cnt_q <= '0;
    end else if (act_q) begin
      if (last_o) begin
        act_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rfc_fwd_sel.sv
module rfc_fwd_sel
  import rfc_pkg::*;
(
  input  port_vec_t rx_i,
  input  port_vec_t alive_i,
  input  port_vec_t up_i,
  input  logic      root_phase_i,
  output port_vec_t fwd_o
);
  port_vec_t base;
  logic      any_down;

  assign base     = alive_i & ~rx_i;
  assign any_down = |(rx_i & ~up_i);
  // arrival on up ports only: send down only, so no down->up turn
  assign fwd_o    = (root_phase_i || any_down) ? base : (base & ~up_i);
endmodule

// File: rtl/rfc_port_dir.sv
module rfc_port_dir
  import rfc_pkg::*;
#(
  parameter int unsigned ID_W = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tag_en_i,
  input  port_vec_t             snd_i,
  input  port_vec_t             rx_i,
  input  port_vec_t             cross_i,
  input  logic [ID_W-1:0]       node_id_i,
  input  logic [NPORT*ID_W-1:0] nbr_id_i,
  output port_vec_t             up_o
);
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic up_q;
    logic id_gt;

    assign id_gt   = node_id_i > nbr_id_i[p*ID_W +: ID_W];
    assign up_o[p] = up_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        up_q <= 1'b0;
      end else if (tag_en_i) begin
        if (rx_i[p])       up_q <= 1'b1;
        else if (snd_i[p]) up_q <= cross_i[p] & id_gt;
      end
    end
  end
endmodule

// File: rtl/rfc_flag_ctrl.sv
module rfc_flag_ctrl
  import rfc_pkg::*;
#(
  parameter int unsigned NODE_CNT = 16,
  localparam int unsigned ID_W = (NODE_CNT > 1) ? $clog2(NODE_CNT) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [ID_W-1:0]       node_id_i,
  input  logic [4*ID_W-1:0]     nbr_id_i,
  input  logic [3:0]            link_ok_i,
  input  logic                  slot_start_i,
  input  logic                  own_slot_i,
  input  logic                  root_req_i,
  input  logic [3:0]            flag_i,
  output logic [3:0]            flag_o,
  output logic                  recovering_o,
  output logic                  rt_clear_o,
  output logic [3:0]            port_up_o,
  output logic [3:0]            rx_mask_o,
  output logic                  rx_valid_o
);
  port_vec_t rx_raw, up_q, fwd_q, fwd_n, flag_d, rx_mask_q, rx_acc;
  logic      seen_q, first_q, rx_valid_q, rt_clear_q;
  logic      rec, last, src_go, root_go, seen_eff, accept, enter, first_eff;

  assign rx_raw    = flag_i & link_ok_i;
  assign src_go    = slot_start_i & own_slot_i & (rec | root_req_i);
  assign root_go   = src_go & ~rec;
  assign seen_eff  = seen_q & ~slot_start_i;
  assign accept    = (|rx_raw) & ~seen_eff & ~src_go & ~last;
  assign enter     = root_go | (accept & ~rec);
  assign first_eff = (first_q & ~slot_start_i) | enter;
  assign rx_acc    = accept ? rx_raw : '0;
  assign flag_d    = (fwd_q | {NPORT{src_go}}) & link_ok_i;

  rfc_exit_timer #(.NODE_CNT(NODE_CNT)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (enter),
    .active_o (rec),
    .last_o   (last)
  );

  rfc_fwd_sel u_fwd (
    .rx_i         (rx_raw),
    .alive_i      (link_ok_i),
    .up_i         (up_q),
    .root_phase_i (first_eff),
    .fwd_o        (fwd_n)
  );

  rfc_port_dir #(.ID_W(ID_W)) u_dir (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tag_en_i  (first_eff),
    .snd_i     (flag_d),
    .rx_i      (rx_acc),
    .cross_i   (rx_raw),
    .node_id_i (node_id_i),
    .nbr_id_i  (nbr_id_i),
    .up_o      (up_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q     <= 1'b0;
      first_q    <= 1'b0;
      fwd_q      <= '0;
      rx_mask_q  <= '0;
      rx_valid_q <= 1'b0;
      rt_clear_q <= 1'b0;
    end else begin
      seen_q     <= last ? 1'b0 : (seen_eff | src_go | accept);
      first_q    <= last ? 1'b0 : first_eff;
      fwd_q      <= accept ? fwd_n : '0;
      rx_mask_q  <= rx_acc;
      rx_valid_q <= accept;
      rt_clear_q <= enter;
    end
  end

  assign flag_o       = flag_d;
  assign recovering_o = rec;
  assign rt_clear_o   = rt_clear_q;
  assign port_up_o    = up_q;
  assign rx_mask_o    = rx_mask_q;
  assign rx_valid_o   = rx_valid_q;
endmodule

// File: rtl/rfc_flag_ctrl_chk.sv
module rfc_flag_ctrl_chk #(
  parameter int unsigned NODE_CNT = 16,
  localparam int unsigned NN = NODE_CNT * NODE_CNT,
  localparam int unsigned RW = $clog2(NN + 2)
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       slot_start_i,
  input logic       own_slot_i,
  input logic       root_req_i,
  input logic [3:0] flag_o,
  input logic       recovering_o,
  input logic       rt_clear_o,
  input logic [3:0] port_up_o,
  input logic [3:0] rx_mask_o,
  input logic       rx_valid_o
);
  logic [RW-1:0] run_q;
  logic          later_q, slot_d, got_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= '0;
      later_q <= 1'b0;
      slot_d  <= 1'b0;
      got_q   <= 1'b0;
    end else begin
      run_q   <= recovering_o ? run_q + 1'b1 : '0;
      later_q <= recovering_o & (later_q | slot_start_i);
      slot_d  <= slot_start_i;
      got_q   <= !recovering_o ? 1'b0 : (slot_d ? rx_valid_o : (got_q | rx_valid_o));
    end
  end

  a_r1_clear_on_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(recovering_o) |-> rt_clear_o);
  a_r1_clear_in_recovery: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rt_clear_o |-> recovering_o);
  a_r2_run_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recovering_o |-> (run_q < RW'(NN)));
  a_r2_run_exact: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(recovering_o) |-> (run_q == RW'(NN)));
  a_r3_send_when_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o != 4'b0) |-> (recovering_o || (slot_start_i && own_slot_i && root_req_i)));
  a_r4_no_echo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && !slot_start_i) |-> ((flag_o & rx_mask_o) == 4'b0));
  a_r7_dirs_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (recovering_o && (later_q || slot_start_i)) |=> $stable(port_up_o));
  a_r10_report_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> (recovering_o && rx_mask_o != 4'b0));
  a_r11_once_per_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && !slot_d) |-> !got_q);
endmodule

bind rfc_flag_ctrl rfc_flag_ctrl_chk #(.NODE_CNT(NODE_CNT)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .slot_start_i (slot_start_i),
  .own_slot_i   (own_slot_i),
  .root_req_i   (root_req_i),
  .flag_o       (flag_o),
  .recovering_o (recovering_o),
  .rt_clear_o   (rt_clear_o),
  .port_up_o    (port_up_o),
  .rx_mask_o    (rx_mask_o),
  .rx_valid_o   (rx_valid_o)
);

// File: tb/rfc_flag_ctrl_tb_top.sv
module rfc_flag_ctrl_tb_top;
  localparam int CLK_P = 10;
  localparam int N     = 4;
  localparam int NN    = N * N;
  localparam int IDW   = 2;

  logic           clk = 1'b0;
  logic           rst_ni = 1'b0;
  logic [IDW-1:0] node_id = 2'd2;
  logic [4*IDW-1:0] nbr_id = {2'd3, 2'd0, 2'd3, 2'd1};
  logic [3:0]     link_ok = 4'b0111;
  logic           slot_start = 1'b0, own_slot = 1'b0, root_req = 1'b0;
  logic [3:0]     flag_in = 4'b0;
  logic [3:0]     flag_out, port_up, rx_mask;
  logic           recovering, rt_clear, rx_valid;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  rfc_flag_ctrl #(.NODE_CNT(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .node_id_i(node_id), .nbr_id_i(nbr_id),
    .link_ok_i(link_ok), .slot_start_i(slot_start), .own_slot_i(own_slot),
    .root_req_i(root_req), .flag_i(flag_in), .flag_o(flag_out),
    .recovering_o(recovering), .rt_clear_o(rt_clear), .port_up_o(port_up),
    .rx_mask_o(rx_mask), .rx_valid_o(rx_valid)
  );

  // behavioural reference state
  bit       m_rec, m_first, m_seen, m_rxv, m_rtc;
  int       m_cnt;
  bit [3:0] m_up, m_fwd, m_rxm;
  // per-cycle derived values
  bit [3:0] e_flag, rx;
  bit       acc, enter, first_eff, src_go, done, seen_eff;

  function automatic bit id_greater(int p);
    return node_id > nbr_id[p*IDW +: IDW];
  endfunction

  task automatic model_comb();
    rx        = flag_in & link_ok;
    src_go    = slot_start && own_slot && (m_rec || root_req);
    seen_eff  = m_seen && !slot_start;
    done      = m_rec && (m_cnt == NN - 1);
    acc       = (rx != 0) && !seen_eff && !src_go && !done;
    enter     = (src_go && !m_rec) || (acc && !m_rec);
    first_eff = (m_first && !slot_start) || enter;
    e_flag    = (m_fwd | (src_go ? 4'hF : 4'h0)) & link_ok;
  endtask

  task automatic model_seq();
    bit [3:0] nup = m_up;
    bit [3:0] nfwd = 0;
    bit down_hit = 0;
    for (int p = 0; p < 4; p++) begin
      if (first_eff && e_flag[p]) nup[p] = flag_in[p] && link_ok[p] && id_greater(p);
      if (first_eff && acc && rx[p]) nup[p] = 1;
      if (rx[p] && !m_up[p]) down_hit = 1;
    end
    if (acc) begin
      for (int p = 0; p < 4; p++)
        nfwd[p] = link_ok[p] && !rx[p] && (first_eff || down_hit || !m_up[p]);
    end
    if (enter) begin m_rec = 1; m_cnt = 0; end
    else if (m_rec) begin
      if (done) begin m_rec = 0; m_cnt = 0; end
      else m_cnt++;
    end
    m_first = done ? 0 : first_eff;
    m_seen  = done ? 0 : (seen_eff || src_go || acc);
    m_up    = nup;
    m_fwd   = nfwd;
    m_rxv   = acc;
    m_rxm   = acc ? rx : 4'b0;
    m_rtc   = enter;
  endtask

  task automatic compare(string req);
    bit bad = 0;
    n_vec++;
    if (flag_out !== e_flag) begin bad = 1;
      $display("FAIL %s flag_o act=%b exp=%b", req, flag_out, e_flag); end
    if (recovering !== m_rec) begin bad = 1;
      $display("FAIL %s recovering_o act=%b exp=%b", req, recovering, m_rec); end
    if (rt_clear !== m_rtc) begin bad = 1;
      $display("FAIL %s rt_clear_o act=%b exp=%b", req, rt_clear, m_rtc); end
    if (port_up !== m_up) begin bad = 1;
      $display("FAIL %s port_up_o act=%b exp=%b", req, port_up, m_up); end
    if (rx_valid !== m_rxv) begin bad = 1;
      $display("FAIL %s rx_valid_o act=%b exp=%b", req, rx_valid, m_rxv); end
    if (rx_mask !== m_rxm) begin bad = 1;
      $display("FAIL %s rx_mask_o act=%b exp=%b", req, rx_mask, m_rxm); end
    if (bad) n_bad++;
  endtask

  task automatic cyc(input logic [3:0] fl, input logic ss, input logic own,
                     input logic rr, input string req);
    flag_in = fl; slot_start = ss; own_slot = own; root_req = rr;
    #1;
    model_comb();
    compare(req);
    @(posedge clk);
    model_seq();
    @(negedge clk);
  endtask

  task automatic idle(int n, string req);
    for (int i = 0; i < n; i++) cyc(4'b0, 0, 0, 0, req);
  endtask

  task automatic run_out(string req);
    while (!(m_rec && m_cnt == NN - 1)) cyc(4'b0, 0, 0, 0, req);
    cyc(4'b0001, 0, 0, 0, req);  // last recovering cycle: flag dropped
    idle(3, req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    model_comb();
    compare("R1");                          // reset state
    rst_ni = 1'b1;
    @(negedge clk);
    idle(2, "R1");
    // own window while normal, no request
    cyc(4'b0, 1, 1, 0, "R12");
    idle(1, "R12");
    // flag on dead port 3 while normal
    cyc(4'b1000, 0, 0, 0, "R9");
    idle(1, "R9");
    // root broadcast arrives from port 0
    cyc(4'b0, 1, 0, 0, "R4");
    cyc(4'b0001, 0, 0, 0, "R1");
    cyc(4'b0110, 0, 0, 0, "R5");            // crossing on ports 1 and 2
    cyc(4'b0001, 0, 0, 0, "R11");
    idle(2, "R5");
    // later window, arrival on up port only
    cyc(4'b0, 1, 0, 0, "R7");
    cyc(4'b0001, 0, 0, 0, "R6");
    cyc(4'b0, 0, 0, 0, "R6");
    cyc(4'b0010, 0, 0, 0, "R11");
    idle(1, "R7");
    // later window, arrival on down port
    cyc(4'b0, 1, 0, 0, "R7");
    cyc(4'b0010, 0, 0, 0, "R6");
    cyc(4'b0, 0, 0, 0, "R6");
    idle(1, "R10");
    // own window while recovering
    cyc(4'b0, 1, 1, 0, "R8");
    cyc(4'b0100, 0, 0, 0, "R8");
    idle(1, "R8");
    // dead port during recovery, then live arrival
    cyc(4'b0, 1, 0, 0, "R9");
    cyc(4'b1000, 0, 0, 0, "R9");
    cyc(4'b0001, 0, 0, 0, "R10");
    idle(2, "R10");
    run_out("R2");
    // this node is root, all links alive
    link_ok = 4'b1111;
    cyc(4'b0, 1, 1, 1, "R3");
    idle(2, "R3");
    cyc(4'b0, 1, 0, 0, "R7");
    cyc(4'b0100, 0, 0, 0, "R6");
    idle(2, "R6");
    run_out("R2");
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule